// File: doc/BRIEF.md
# Display Pixel Input Formatter

This block sits between a video encoder and a display serial host. It takes one pixel per clock as three 10-bit colour components together with data-enable, horizontal sync and vertical sync. It turns active-low syncs into active-high ones and trims the components to the configured input depth. It can place any input component in any output slot, and it packs the result as 24-bit RGB, 18-bit RGB or 16-bit YCbCr 4:2:2. For 4:2:2 output, chroma comes from the even pixel of each pair, from the odd pixel, or from the rounded average of the two.

All settings come from one 32-bit control word, written with a single-cycle strobe. A written word is held as pending. It becomes active only on the next rising edge of the corrected vertical sync, so a frame is never formatted with mixed settings. Every output, data and syncs alike, follows its input by exactly two clock cycles.

Top module: `dpf_formatter`

## Requirements
- R1: After reset the active and pending settings are: all three slot selects equal to their own slot number, no sync inversion, input width code 0, chroma method 0 and format code 0. All outputs are 0.
- R2: Control bit 6 inverts DE, bit 5 inverts HSYNC and bit 4 inverts VSYNC. This applies to both the outputs and the internal use of those signals.
- R3: out_de, out_hs, out_vs and out_pix show the input sampled two clock edges earlier.
- R4: Bits [9:8], [11:10] and [13:12] select the source component for slot 0 (R/Y), slot 1 (G/Cb) and slot 2 (B/Cr). Code 0, 1 or 2 picks in_c0, in_c1 or in_c2, and code 3 gives zero.
- R5: Bits [18:16] set the input width, and each component keeps only its upper bits. Code 1 keeps 8 bits, code 2 keeps 6 bits, and code 3 keeps 5 bits for c0 and c2 and 6 bits for c1. Codes 0 and 4 to 7 keep all 10 bits.
- R6: Format code 5 in bits [23:20], and every code other than 4 or 8, gives out_pix = {slot0[9:2], slot1[9:2], slot2[9:2]}.
- R7: Format code 4 gives out_pix = {6'b0, slot0[9:4], slot1[9:4], slot2[9:4]}.
- R8: Format code 8 gives out_pix = {8'b0, Y[9:2], C[9:2]}, where Y is slot 0. An even pixel carries Cb (slot 1) and an odd pixel carries Cr (slot 2). Pixel parity restarts at even on every rising edge of the corrected DE.
- R9: Bits [15:14] choose the chroma for a pair. Code 0 takes the even pixel's chroma, code 1 takes the odd pixel's, and code 2 takes (even + odd + 1) >> 1 computed on 10 bits. Code 3 behaves as code 0.
- R10: When an even pixel is the last one of a DE run, its own chroma stands in for the missing odd neighbour.
- R11: A written control word takes effect on the first clock edge after the edge at which the corrected VSYNC rises. Until then, writes leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Strobe that loads cfg_wdata as pending settings |
| cfg_wdata | input | 32 | Control word |
| in_de | input | 1 | Data enable from encoder |
| in_hs | input | 1 | Horizontal sync from encoder |
| in_vs | input | 1 | Vertical sync from encoder |
| in_c0 | input | 10 | Input component 0 |
| in_c1 | input | 10 | Input component 1 |
| in_c2 | input | 10 | Input component 2 |
| out_de | output | 1 | Corrected, delayed data enable |
| out_hs | output | 1 | Corrected, delayed horizontal sync |
| out_vs | output | 1 | Corrected, delayed vertical sync |
| out_pix | output | 24 | Packed output pixel |

## Verification
The delay properties assume the inputs are known on every clock after reset. The stimulus always drives defined values. The configuration-stability property assumes settings change only across a corrected VSYNC rise. The bench therefore applies each new word by writing it and then toggling raw VSYNC, which produces such a rise under either polarity. Random phases hold raw VSYNC low, and DE runs start from a low cycle, so parity restarts are well defined for the reference functions.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

    localparam int LANE_W = 8;
    localparam int NARROW_W = 6;

    localparam logic [3:0] FMT_RGB666 = 4'd4;
    localparam logic [3:0] FMT_YC422  = 4'd8;

    localparam logic [1:0] CH_ODD = 2'd1;
    localparam logic [1:0] CH_AVG = 2'd2;

    typedef struct packed {
        logic [3:0] fmt;
        logic [2:0] width;
        logic [1:0] chroma;
        logic [1:0] sel2;
        logic [1:0] sel1;
        logic [1:0] sel0;
        logic       inv_de;
        logic       inv_hs;
        logic       inv_vs;
    } dpf_cfg_t;

    localparam dpf_cfg_t CFG_RST = '{
        fmt: 4'd0, width: 3'd0, chroma: 2'd0,
        sel2: 2'd2, sel1: 2'd1, sel0: 2'd0,
        inv_de: 1'b0, inv_hs: 1'b0, inv_vs: 1'b0
    };

    function automatic dpf_cfg_t cfg_decode(input logic [31:0] w);
        dpf_cfg_t c;
        c.fmt    = w[23:20];
        c.width  = w[18:16];
        c.chroma = w[15:14];
        c.sel2   = w[13:12];
        c.sel1   = w[11:10];
        c.sel0   = w[9:8];
        c.inv_de = w[6];
        c.inv_hs = w[5];
        c.inv_vs = w[4];
        return c;
    endfunction

endpackage

// File: rtl/dpf_cfg_regs.sv
module dpf_cfg_regs
    import dpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        vs_rise,
    output dpf_cfg_t    act_cfg
);

    typedef struct packed {
        dpf_cfg_t pend;
        dpf_cfg_t act;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vs_rise) st_d.act = st_q.pend;
        if (wr_en)   st_d.pend = cfg_decode(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= CFG_RST;
            st_q.act  <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;

endmodule

// File: rtl/dpf_input_stage.sv
module dpf_input_stage
    import dpf_pkg::*;
#(
    parameter int COMP_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  dpf_cfg_t                    cfg,
    input  logic                        in_de,
    input  logic                        in_hs,
    input  logic                        in_vs,
    input  logic [2:0][COMP_W-1:0]      in_comp,
    output logic                        live_de,
    output logic [2:0][COMP_W-1:0]      live_comp,
    output logic                        vs_rise,
    output logic                        s_de,
    output logic                        s_hs,
    output logic                        s_vs,
    output logic                        s_par,
    output logic [2:0][COMP_W-1:0]      s_comp
);

    localparam int KEEP_24 = 8;
    localparam int KEEP_18 = 6;
    localparam int KEEP_565 = 5;

    function automatic logic [COMP_W-1:0] top_mask(input int keep);
        logic [COMP_W-1:0] m;
        m = '1;
        m = m << (COMP_W - keep);
        return m;
    endfunction

    typedef struct packed {
        logic                   de;
        logic                   hs;
        logic                   vs;
        logic                   par;
        logic [2:0][COMP_W-1:0] comp;
    } stage_t;

    stage_t st_d, st_q;
    logic [2:0][COMP_W-1:0] trimmed;
    logic [2:0][1:0]        sel_arr;
    logic                   live_hs, live_vs;

    assign sel_arr = {cfg.sel2, cfg.sel1, cfg.sel0};

    for (genvar k = 0; k < 3; k++) begin : g_comp
        localparam int KEEP_16 = (k == 1) ? KEEP_18 : KEEP_565;
        always_comb begin
            case (cfg.width)
                3'd1:    trimmed[k] = in_comp[k] & top_mask(KEEP_24);
                3'd2:    trimmed[k] = in_comp[k] & top_mask(KEEP_18);
                3'd3:    trimmed[k] = in_comp[k] & top_mask(KEEP_16);
                default: trimmed[k] = in_comp[k];
            endcase
        end
        always_comb begin
            case (sel_arr[k])
                2'd0:    live_comp[k] = trimmed[0];
                2'd1:    live_comp[k] = trimmed[1];
                2'd2:    live_comp[k] = trimmed[2];
                default: live_comp[k] = '0;
            endcase
        end
    end

    assign live_de = in_de ^ cfg.inv_de;
    assign live_hs = in_hs ^ cfg.inv_hs;
    assign live_vs = in_vs ^ cfg.inv_vs;
    assign vs_rise = live_vs & ~st_q.vs;

    always_comb begin
        st_d.de   = live_de;
        st_d.hs   = live_hs;
        st_d.vs   = live_vs;
        st_d.par  = live_de & st_q.de & ~st_q.par;
        st_d.comp = live_comp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_de   = st_q.de;
    assign s_hs   = st_q.hs;
    assign s_vs   = st_q.vs;
    assign s_par  = st_q.par;
    assign s_comp = st_q.comp;

endmodule

// File: rtl/dpf_output_stage.sv
module dpf_output_stage
    import dpf_pkg::*;
#(
    parameter int COMP_W = 10,
    localparam int OUT_W = 3 * LANE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  dpf_cfg_t                    cfg,
    input  logic                        s_de,
    input  logic                        s_hs,
    input  logic                        s_vs,
    input  logic                        s_par,
    input  logic [2:0][COMP_W-1:0]      s_comp,
    input  logic                        live_de,
    input  logic [2:0][COMP_W-1:0]      live_comp,
    output logic                        out_de,
    output logic                        out_hs,
    output logic                        out_vs,
    output logic [OUT_W-1:0]            out_pix
);

    function automatic logic [COMP_W-1:0] pick_chroma(
        input logic [1:0]        mode,
        input logic [COMP_W-1:0] own,
        input logic [COMP_W-1:0] nb
    );
        logic [COMP_W:0] sum;
        sum = {1'b0, own} + {1'b0, nb} + {{COMP_W{1'b0}}, 1'b1};
        case (mode)
            CH_ODD:  return nb;
            CH_AVG:  return sum[COMP_W:1];
            default: return own;
        endcase
    endfunction

    typedef struct packed {
        logic              de;
        logic              hs;
        logic              vs;
        logic [OUT_W-1:0]  pix;
        logic [COMP_W-1:0] cr_hold;
    } out_st_t;

    out_st_t st_d, st_q;
    logic [2:0][COMP_W-1:0] nb_comp;
    logic [COMP_W-1:0]      cb_val, cr_pair, c_sel;

    always_comb begin
        nb_comp = live_de ? live_comp : s_comp;
        cb_val  = pick_chroma(cfg.chroma, s_comp[1], nb_comp[1]);
        cr_pair = pick_chroma(cfg.chroma, s_comp[2], nb_comp[2]);
        c_sel   = s_par ? st_q.cr_hold : cb_val;

        st_d         = st_q;
        st_d.de      = s_de;
        st_d.hs      = s_hs;
        st_d.vs      = s_vs;
        if (s_de && !s_par) st_d.cr_hold = cr_pair;

        case (cfg.fmt)
            FMT_RGB666: st_d.pix = {{(OUT_W - 3 * NARROW_W){1'b0}},
                                    s_comp[0][COMP_W-1 -: NARROW_W],
                                    s_comp[1][COMP_W-1 -: NARROW_W],
                                    s_comp[2][COMP_W-1 -: NARROW_W]};
            FMT_YC422:  st_d.pix = {{LANE_W{1'b0}},
                                    s_comp[0][COMP_W-1 -: LANE_W],
                                    c_sel[COMP_W-1 -: LANE_W]};
            default:    st_d.pix = {s_comp[0][COMP_W-1 -: LANE_W],
                                    s_comp[1][COMP_W-1 -: LANE_W],
                                    s_comp[2][COMP_W-1 -: LANE_W]};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_de  = st_q.de;
    assign out_hs  = st_q.hs;
    assign out_vs  = st_q.vs;
    assign out_pix = st_q.pix;

endmodule

// File: rtl/dpf_formatter.sv
module dpf_formatter
    import dpf_pkg::*;
#(
    parameter int COMP_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [31:0]           cfg_wdata,
    input  logic                  in_de,
    input  logic                  in_hs,
    input  logic                  in_vs,
    input  logic [COMP_W-1:0]     in_c0,
    input  logic [COMP_W-1:0]     in_c1,
    input  logic [COMP_W-1:0]     in_c2,
    output logic                  out_de,
    output logic                  out_hs,
    output logic                  out_vs,
    output logic [3*LANE_W-1:0]   out_pix
);

    dpf_cfg_t               act_cfg;
    logic                   vs_rise;
    logic                   live_de;
    logic [2:0][COMP_W-1:0] live_comp;
    logic                   s_de, s_hs, s_vs, s_par;
    logic [2:0][COMP_W-1:0] s_comp;

    dpf_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .vs_rise (vs_rise),
        .act_cfg (act_cfg)
    );

    dpf_input_stage #(.COMP_W(COMP_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (act_cfg),
        .in_de     (in_de),
        .in_hs     (in_hs),
        .in_vs     (in_vs),
        .in_comp   ({in_c2, in_c1, in_c0}),
        .live_de   (live_de),
        .live_comp (live_comp),
        .vs_rise   (vs_rise),
        .s_de      (s_de),
        .s_hs      (s_hs),
        .s_vs      (s_vs),
        .s_par     (s_par),
        .s_comp    (s_comp)
    );

    dpf_output_stage #(.COMP_W(COMP_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (act_cfg),
        .s_de      (s_de),
        .s_hs      (s_hs),
        .s_vs      (s_vs),
        .s_par     (s_par),
        .s_comp    (s_comp),
        .live_de   (live_de),
        .live_comp (live_comp),
        .out_de    (out_de),
        .out_hs    (out_hs),
        .out_vs    (out_vs),
        .out_pix   (out_pix)
    );

endmodule

// File: rtl/dpf_checker.sv
module dpf_checker
    import dpf_pkg::*;
#(
    parameter int COMP_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_de,
    input logic                   in_hs,
    input logic                   in_vs,
    input logic                   out_de,
    input logic                   out_hs,
    input logic                   out_vs,
    input logic [3*LANE_W-1:0]    out_pix,
    input dpf_cfg_t               act,
    input logic                   vs_rise,
    input logic                   s_de,
    input logic                   s_par,
    input logic [2:0][COMP_W-1:0] s_comp
);

    logic [1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen <= '0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    AST_DE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> out_de == ($past(in_de, 2) ^ $past(act.inv_de, 2))); // R3
    AST_HS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> out_hs == ($past(in_hs, 2) ^ $past(act.inv_hs, 2))); // R2
    AST_VS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> out_vs == ($past(in_vs, 2) ^ $past(act.inv_vs, 2))); // R2
    AST_CFG_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && !$past(vs_rise)) |-> $stable(act)); // R11
    AST_PARITY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_de) |-> !s_par); // R8
    AST_YC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && $past(act.fmt) == FMT_YC422) |-> out_pix[3*LANE_W-1 -: LANE_W] == '0); // R8
    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && $past(act.fmt) == FMT_RGB666)
        |-> out_pix[3*LANE_W-1 -: 3*LANE_W-3*NARROW_W] == '0); // R7
    AST_WIDTH24_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && $past(act.width) == 3'd1)
        |-> (s_comp[0][1:0] == 2'b0 && s_comp[1][1:0] == 2'b0 && s_comp[2][1:0] == 2'b0)); // R5

endmodule

bind dpf_formatter dpf_checker #(.COMP_W(COMP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_de   (in_de),
    .in_hs   (in_hs),
    .in_vs   (in_vs),
    .out_de  (out_de),
    .out_hs  (out_hs),
    .out_vs  (out_vs),
    .out_pix (out_pix),
    .act     (act_cfg),
    .vs_rise (vs_rise),
    .s_de    (s_de),
    .s_par   (s_par),
    .s_comp  (s_comp)
);

// File: tb/dpf_formatter_test.sv
module dpf_formatter_test;
    import dpf_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic [9:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic        out_de, out_hs, out_vs;
    logic [23:0] out_pix;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpf_formatter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_pix(out_pix)
    );

    // reference state, built from the requirements
    dpf_cfg_t         m_act, m_pend;
    logic             m_sde, m_shs, m_svs, m_spar;
    logic [2:0][9:0]  m_sc;
    logic [9:0]       m_cr;
    logic             m_ode, m_ohs, m_ovs;
    logic [23:0]      m_opix;
    logic             wr_req = 1'b0;
    logic [31:0]      wr_word = '0;

    function automatic logic [31:0] mkcfg(input logic [3:0] f, input logic [2:0] w,
        input logic [1:0] ch, input logic [1:0] s2, input logic [1:0] s1,
        input logic [1:0] s0, input logic ide, input logic ihs, input logic ivs);
        return {8'h00, f, 1'b0, w, ch, s2, s1, s0, 1'b0, ide, ihs, ivs, 4'h0};
    endfunction

    function automatic logic [9:0] trim(input logic [2:0] w, input int k, input logic [9:0] v);
        case (w)
            3'd1: return v & 10'h3FC;                           // R5
            3'd2: return v & 10'h3F0;
            3'd3: return (k == 1) ? (v & 10'h3F0) : (v & 10'h3E0);
            default: return v;
        endcase
    endfunction

    function automatic logic [9:0] chsel(input logic [1:0] m, input logic [9:0] e, input logic [9:0] o);
        logic [10:0] s;
        s = {1'b0, e} + {1'b0, o} + 11'd1;
        case (m)
            2'd1: return o;
            2'd2: return s[10:1];                                // R9
            default: return e;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic de, input logic hs, input logic vs,
                       input logic [9:0] a, input logic [9:0] b, input logic [9:0] c);
        logic [2:0][9:0] raw, live, nb;
        logic [2:0][1:0] sels;
        logic lde, lhs, lvs, vr, npar;
        logic [9:0] cb, crp, csel;
        string tag;
        in_de = de; in_hs = hs; in_vs = vs; in_c0 = a; in_c1 = b; in_c2 = c;
        cfg_wr = wr_req; cfg_wdata = wr_word;
        lde = de ^ m_act.inv_de; lhs = hs ^ m_act.inv_hs; lvs = vs ^ m_act.inv_vs;
        raw[0] = trim(m_act.width, 0, a);
        raw[1] = trim(m_act.width, 1, b);
        raw[2] = trim(m_act.width, 2, c);
        sels = {m_act.sel2, m_act.sel1, m_act.sel0};
        for (int k = 0; k < 3; k++) live[k] = (sels[k] == 2'd3) ? 10'd0 : raw[sels[k]];
        vr = lvs && !m_svs;
        nb = lde ? live : m_sc;
        cb = chsel(m_act.chroma, m_sc[1], nb[1]);
        crp = chsel(m_act.chroma, m_sc[2], nb[2]);
        csel = m_spar ? m_cr : cb;
        case (m_act.fmt)
            4'd4: begin m_opix = {6'b0, m_sc[0][9:4], m_sc[1][9:4], m_sc[2][9:4]}; tag = "R7"; end
            4'd8: begin m_opix = {8'b0, m_sc[0][9:2], csel[9:2]}; tag = "R8/R9/R10"; end
            default: begin m_opix = {m_sc[0][9:2], m_sc[1][9:2], m_sc[2][9:2]}; tag = "R6/R4/R5"; end
        endcase
        m_ode = m_sde; m_ohs = m_shs; m_ovs = m_svs;
        if (m_sde && !m_spar) m_cr = crp;
        npar = lde && m_sde && !m_spar;
        m_sde = lde; m_shs = lhs; m_svs = lvs; m_spar = npar; m_sc = live;
        if (vr) m_act = m_pend;                                   // R11
        if (wr_req) m_pend = cfg_decode(wr_word);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; wr_req = 1'b0;
        check({tag, " pix"}, {8'h0, out_pix}, {8'h0, m_opix});
        check("R3/R2 syncs", {29'h0, out_de, out_hs, out_vs}, {29'h0, m_ode, m_ohs, m_ovs});
    endtask

    task automatic apply_cfg(input logic [31:0] w);
        wr_req = 1'b1; wr_word = w;
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic yc_pair(input logic [1:0] m, input logic [23:0] e_even, input logic [23:0] e_odd);
        apply_cfg(mkcfg(4'd8, 3'd0, m, 2'd2, 2'd1, 2'd0, 0, 0, 0));
        cyc(0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 10'd400, 10'd100, 10'd40);
        cyc(1, 0, 0, 10'd404, 10'd203, 10'd81);
        check("R9 even pixel", {8'h0, out_pix}, {8'h0, e_even});
        cyc(0, 0, 0, 0, 0, 0);
        check("R9 odd pixel", {8'h0, out_pix}, {8'h0, e_odd});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_act = CFG_RST; m_pend = CFG_RST;
        m_sde = 0; m_shs = 0; m_svs = 0; m_spar = 0; m_sc = '0; m_cr = '0;
        m_ode = 0; m_ohs = 0; m_ovs = 0; m_opix = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {4'h0, out_pix, out_de, out_hs, out_vs, 1'b0}, 32'h0);
        rst_n = 1'b1;

        // R1 defaults: identity routing, 24-bit passthrough
        cyc(1, 0, 0, 10'h040, 10'h080, 10'h0C0);
        cyc(0, 0, 0, 0, 0, 0);
        check("R1 default format", {8'h0, out_pix}, 32'h00102030);

        // R11 write held until vsync, then R2 DE inversion
        wr_req = 1'b1; wr_word = mkcfg(4'd5, 3'd0, 2'd0, 2'd2, 2'd1, 2'd0, 1, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        check("R11 write before vsync", {31'h0, out_de}, 32'h1);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        check("R2 DE inverted", {31'h0, out_de}, 32'h0);

        // R4 crossbar
        apply_cfg(mkcfg(4'd5, 3'd0, 2'd0, 2'd1, 2'd0, 2'd2, 0, 0, 0));
        cyc(1, 0, 0, 10'h040, 10'h080, 10'h0C0);
        cyc(0, 0, 0, 0, 0, 0);
        check("R4 routing", {8'h0, out_pix}, 32'h00301020);
        apply_cfg(mkcfg(4'd5, 3'd0, 2'd0, 2'd3, 2'd1, 2'd0, 0, 0, 0));
        cyc(1, 0, 0, 10'h3FF, 10'h3FF, 10'h3FF);
        cyc(0, 0, 0, 0, 0, 0);
        check("R4 select code 3", {8'h0, out_pix}, 32'h00FFFF00);

        // R5 565 trimming
        apply_cfg(mkcfg(4'd5, 3'd3, 2'd0, 2'd2, 2'd1, 2'd0, 0, 0, 0));
        cyc(1, 0, 0, 10'h3FF, 10'h3FF, 10'h3FF);
        cyc(0, 0, 0, 0, 0, 0);
        check("R5 width 16", {8'h0, out_pix}, 32'h00F8FCF8);

        // R6 unsupported code
        apply_cfg(mkcfg(4'd15, 3'd0, 2'd0, 2'd2, 2'd1, 2'd0, 0, 0, 0));
        cyc(1, 0, 0, 10'h155, 10'h2AA, 10'h3FF);
        cyc(0, 0, 0, 0, 0, 0);
        check("R6 unsupported format", {8'h0, out_pix}, 32'h0055AAFF);

        // R7 narrow RGB
        apply_cfg(mkcfg(4'd4, 3'd0, 2'd0, 2'd2, 2'd1, 2'd0, 0, 0, 0));
        cyc(1, 0, 0, 10'h3FF, 10'h000, 10'h2AA);
        cyc(0, 0, 0, 0, 0, 0);
        check("R7 18-bit packing", {8'h0, out_pix}, 32'h0003F02A);

        // R8/R9 chroma methods on one pair
        yc_pair(2'd2, 24'h006426, 24'h00650F);
        yc_pair(2'd0, 24'h006419, 24'h00650A);
        yc_pair(2'd1, 24'h006432, 24'h006514);

        // R10 lone even pixel at end of run
        apply_cfg(mkcfg(4'd8, 3'd0, 2'd2, 2'd2, 2'd1, 2'd0, 0, 0, 0));
        cyc(1, 0, 0, 10'd400, 10'd100, 10'd40);
        cyc(0, 0, 0, 10'd0, 10'd900, 10'd900);
        check("R10 lone pixel", {8'h0, out_pix}, 32'h00006419);

        // random phases
        for (int p = 0; p < 10; p++) begin
            logic [3:0] f;
            case (p % 4)
                0: f = 4'd4;
                1: f = 4'd5;
                2: f = 4'd8;
                default: f = 4'($urandom_range(0, 15));
            endcase
            apply_cfg(mkcfg(f, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                            2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                            2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))));
            for (int ln = 0; ln < 25; ln++) begin
                int len;
                len = $urandom_range(1, 40);
                cyc(0, 1, 0, 10'($urandom), 10'($urandom), 10'($urandom));
                cyc(0, 0, 0, 10'($urandom), 10'($urandom), 10'($urandom));
                for (int i = 0; i < len; i++)
                    cyc(1, 0, 0, 10'($urandom), 10'($urandom), 10'($urandom));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule